// File: doc/BRIEF.md
# Lockable Register Write-Protection Controller

This block is a small register-bus peripheral. It holds one 16-bit protection control register that guards two groups of configuration registers. The first group holds pin-multiplexing and I/O-cell settings. The second group holds peripheral clock enables, stop-disable settings and clock rates. The block also provides both groups as plain storage behind the same bus. This keeps the effect of protection visible at the ports.

Each group has a two-bit protection control. One bit turns write blocking on or off. The other bit freezes that setting until the next reset. While a control is unlocked, software may turn protection on and off as often as it likes. Once a control is locked, nothing but reset can change it. A write to a group whose protection is on leaves the target register untouched and raises a one-cycle write-error pulse. Reads are never blocked.

The bus is synchronous and has no handshake. The address, write enable and write data are sampled on each rising edge. Read data for the sampled address appears one cycle later.

Top module: `wprot_ctrl`

## Requirements
- R1: In the protection register (address 0x00), bits 15..4 always read as zero, and writes to them have no effect on any state.
- R2: Bit 0 is the protect bit of the pin group and bit 1 is its lock bit. Bit 2 is the protect bit of the clock group and bit 3 is its lock bit. A protect bit of 1 blocks writes to its group.
- R3: Synchronous active-high reset returns all four control bits to 0, which means unprotected and unlocked. Group storage is not cleared by reset.
- R4: While a field's lock bit is 0, a write to address 0x00 loads both bits of that field from the write data, so protection can be set and cleared any number of times.
- R5: Once a field's lock bit is 1, writes cannot change either bit of that field until reset. A single write may set protect and lock together, and both values then hold.
- R6: The two fields are independent. Locking or protecting one field does not change whether the other field can be written.
- R7: The pin group is the 8 registers at 0x10..0x17. While bit 0 is 1, writes to them leave their contents unchanged. While bit 0 is 0, a write stores the full 16-bit data.
- R8: The clock group is the 6 registers at 0x20..0x25. While bit 2 is 1, writes to them leave their contents unchanged. While bit 2 is 0, a write stores the full 16-bit data.
- R9: `wr_err` is 1 during exactly the cycle after an edge at which a write to a protected group was sampled, and is 0 after every other edge.
- R10: Reads are never blocked. `rd_data` after an edge shows the contents the sampled address held before that edge's write.
- R11: A write to 0x00 first governs group writes sampled at the next edge.
- R12: Addresses outside 0x00, 0x10..0x17 and 0x20..0x25 read as zero, and writes to them change nothing and raise no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 6 | Register address |
| wr_en | input | 1 | Write strobe for the sampled address |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Contents of the address sampled at the previous edge |
| wr_err | output | 1 | One-cycle pulse after a blocked write |

## Verification
The control state has only four bits, and a wrong value shows up at the ports in two ways. The first is a read of address 0x00, which shows it one cycle after the read. The second is a wrong outcome for the next group write: the wrong `wr_err` appears one cycle later, and the wrong stored value appears on a read one more cycle after that. The bench sweeps every unlocked protect combination against every group register. It then runs lock sequences on each field separately, including locking with protection off and locking with protection on in one write. A reference model in the bench follows the requirements, and every access compares both `rd_data` and `wr_err` against it.

// File: rtl/wprot_pkg.sv
package wprot_pkg;
  localparam int DATA_W   = 16;
  localparam int FIELD_W  = 2;
  localparam int N_GROUPS = 2;
  localparam int CTRL_W   = FIELD_W * N_GROUPS;

  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_CTRL = 2'd1,
    RGN_PIN  = 2'd2,
    RGN_CLK  = 2'd3
  } region_e;
endpackage

// File: rtl/wprot_field.sv
module wprot_field (
  input  logic clk,
  input  logic rst,
  input  logic wr,
  input  logic new_prot,
  input  logic new_lock,
  output logic prot,
  output logic lock
);
  always_ff @(posedge clk) begin
    if (rst) begin
      prot <= 1'b0;
      lock <= 1'b0;
    end else if (wr && !lock) begin
      prot <= new_prot;
      lock <= new_lock;
    end
  end

  assert_lock_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    lock |=> (lock && $stable(prot)));

  assert_open_load_R4: assert property (@(posedge clk) disable iff (rst)
    (wr && !lock) |=> (prot == $past(new_prot) && lock == $past(new_lock)));

  assert_reset_clear_R3: assert property (@(posedge clk)
    $past(rst) |-> (!prot && !lock));
endmodule

// File: rtl/wprot_bank.sv
module wprot_bank #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  parameter int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_req,
  input  logic              protect,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_q,
  output logic              blocked
);
  localparam int MEM_DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [MEM_DEPTH];

  assign blocked = wr_req && protect;

  always_ff @(posedge clk) begin
    if (wr_req && !protect) mem[idx] <= wdata;
    rd_q <= mem[idx];
  end

  assert_blocked_keeps_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_req && protect) |=> (mem[$past(idx)] == $past(mem[idx])));

  // R8 uses the same bank for the clock group
  assert_open_write_lands_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !protect) |=> (mem[$past(idx)] == $past(wdata)));
endmodule

// File: rtl/wprot_ctrl.sv
module wprot_ctrl
  import wprot_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int CTRL_ADR = 0,
  parameter int PIN_BASE = 16,
  parameter int PIN_REGS = 8,
  parameter int CLK_BASE = 32,
  parameter int CLK_REGS = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              wr_err
);
  localparam int PIN_IDX_W = (PIN_REGS > 1) ? $clog2(PIN_REGS) : 1;
  localparam int CLK_IDX_W = (CLK_REGS > 1) ? $clog2(CLK_REGS) : 1;
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADR);
  localparam logic [ADDR_W:0]   PIN_LO = (ADDR_W+1)'(PIN_BASE);
  localparam logic [ADDR_W:0]   PIN_HI = (ADDR_W+1)'(PIN_BASE + PIN_REGS);
  localparam logic [ADDR_W:0]   CLK_LO = (ADDR_W+1)'(CLK_BASE);
  localparam logic [ADDR_W:0]   CLK_HI = (ADDR_W+1)'(CLK_BASE + CLK_REGS);

  logic [ADDR_W:0]    addr_x;
  region_e            region, region_q;
  logic [N_GROUPS-1:0] grp_prot, grp_lock;
  logic [CTRL_W-1:0]  ctrl_view, ctrl_q;
  logic [PIN_IDX_W-1:0] pin_idx;
  logic [CLK_IDX_W-1:0] clk_idx;
  logic [DATA_W-1:0]  pin_q, clk_q;
  logic               pin_blk, clk_blk;

  assign addr_x = {1'b0, addr};

  always_comb begin
    if (addr == CTRL_A)                        region = RGN_CTRL;
    else if (addr_x >= PIN_LO && addr_x < PIN_HI) region = RGN_PIN;
    else if (addr_x >= CLK_LO && addr_x < CLK_HI) region = RGN_CLK;
    else                                        region = RGN_NONE;
  end

  assign pin_idx = PIN_IDX_W'(addr_x - PIN_LO);
  assign clk_idx = CLK_IDX_W'(addr_x - CLK_LO);

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_field
    wprot_field u_field (
      .clk      (clk),
      .rst      (rst),
      .wr       (wr_en && region == RGN_CTRL),
      .new_prot (wr_data[FIELD_W*g]),
      .new_lock (wr_data[FIELD_W*g+1]),
      .prot     (grp_prot[g]),
      .lock     (grp_lock[g])
    );
    assign ctrl_view[FIELD_W*g]   = grp_prot[g];
    assign ctrl_view[FIELD_W*g+1] = grp_lock[g];
  end

  wprot_bank #(.DATA_W(DATA_W), .DEPTH(PIN_REGS), .IDX_W(PIN_IDX_W)) u_pin_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_req  (wr_en && region == RGN_PIN),
    .protect (grp_prot[0]),
    .idx     (pin_idx),
    .wdata   (wr_data),
    .rd_q    (pin_q),
    .blocked (pin_blk)
  );

  wprot_bank #(.DATA_W(DATA_W), .DEPTH(CLK_REGS), .IDX_W(CLK_IDX_W)) u_clk_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_req  (wr_en && region == RGN_CLK),
    .protect (grp_prot[1]),
    .idx     (clk_idx),
    .wdata   (wr_data),
    .rd_q    (clk_q),
    .blocked (clk_blk)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      region_q <= RGN_NONE;
      ctrl_q   <= '0;
      wr_err   <= 1'b0;
    end else begin
      region_q <= region;
      ctrl_q   <= ctrl_view;
      wr_err   <= pin_blk || clk_blk;
    end
  end

  always_comb begin
    case (region_q)
      RGN_CTRL: rd_data = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
      RGN_PIN:  rd_data = pin_q;
      RGN_CLK:  rd_data = clk_q;
      default:  rd_data = '0;
    endcase
  end

  assert_err_needs_write_R9: assert property (@(posedge clk) disable iff (rst)
    wr_err |-> ($past(wr_en) && $past(region == RGN_PIN || region == RGN_CLK)));

  assert_ctrl_read_upper_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (region_q == RGN_CTRL) |-> (rd_data[DATA_W-1:CTRL_W] == '0));

  assert_unmapped_reads_zero_R12: assert property (@(posedge clk) disable iff (rst)
    ($past(region) == RGN_NONE && !$past(rst)) |-> (rd_data == '0));
endmodule

// File: tb/test_wprot_ctrl.sv
module test_wprot_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        wr_err;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  logic [1:0]  m_prot, m_lock;
  logic [15:0] m_pin [8];
  logic [15:0] m_clk [6];

  wprot_ctrl i_wprot_ctrl (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .wr_err(wr_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] model_read(input logic [5:0] a);
    if (a == 6'h00) return {12'h000, m_lock[1], m_prot[1], m_lock[0], m_prot[0]};
    if (a >= 6'h10 && a < 6'h18) return m_pin[a - 6'h10];
    if (a >= 6'h20 && a < 6'h26) return m_clk[a - 6'h20];
    return 16'h0000;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one bus cycle; inputs change 1 time unit after an edge
  task automatic access(input logic [5:0] a, input logic we, input logic [15:0] d,
                        input string req, input bit chk_rd);
    logic [15:0] exp_rd;
    logic        exp_err;
    exp_rd  = model_read(a);
    exp_err = 1'b0;
    if (we) begin
      if (a == 6'h00) begin
        for (int g = 0; g < 2; g++)
          if (!m_lock[g]) begin
            m_prot[g] = d[2*g];
            m_lock[g] = d[2*g+1];
          end
      end else if (a >= 6'h10 && a < 6'h18) begin
        if (m_prot[0]) exp_err = 1'b1; else m_pin[a - 6'h10] = d;
      end else if (a >= 6'h20 && a < 6'h26) begin
        if (m_prot[1]) exp_err = 1'b1; else m_clk[a - 6'h20] = d;
      end
    end
    addr = a; wr_en = we; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
    if (chk_rd) check({req, " rd_data"}, rd_data, exp_rd);
    check({req, " wr_err"}, {15'b0, wr_err}, {15'b0, exp_err});
  endtask

  task automatic do_reset();
    rst = 1'b1; wr_en = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    rst = 1'b0;
    m_prot = '0; m_lock = '0;
  endtask

  task automatic read_all(input string req);
    access(6'h00, 1'b0, 16'h0, req, 1);
    for (int i = 0; i < 8; i++) access(6'(16 + i), 1'b0, 16'h0, req, 1);
    for (int i = 0; i < 6; i++) access(6'(32 + i), 1'b0, 16'h0, req, 1);
    access(6'h00, 1'b0, 16'h0, req, 1);
  endtask

  task automatic hit_groups(input logic [15:0] seed, input string req);
    for (int i = 0; i < 8; i++) access(6'(16 + i), 1'b1, seed ^ 16'(i * 16'h1111), req, 1);
    for (int i = 0; i < 6; i++) access(6'(32 + i), 1'b1, ~seed + 16'(i * 16'h0707), req, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    m_prot = '0; m_lock = '0;
    do_reset();
    // R3: control register reads zero after reset
    access(6'h00, 1'b0, 16'h0, "R3", 1);
    // fill storage without checking unknown old contents
    for (int i = 0; i < 8; i++) access(6'(16 + i), 1'b1, 16'hA000 + 16'(i), "R7", 0);
    for (int i = 0; i < 6; i++) access(6'(32 + i), 1'b1, 16'h5000 + 16'(i), "R8", 0);
    read_all("R10");

    // R2 R4 R7 R8 R9 R11 R1: sweep every unlocked protect combination
    for (int p = 0; p < 4; p++) begin
      access(6'h00, 1'b1, 16'hFFF0 | {13'b0, p[1], 1'b0, p[0]}, "R4", 1);
      access(6'h00, 1'b0, 16'h0, "R1", 1);
      hit_groups(16'(p * 16'h3C5A + 16'h0101), "R11");
      read_all("R2");
    end
    // R4: set and clear repeatedly
    for (int k = 0; k < 6; k++) access(6'h00, 1'b1, 16'(k & 5), "R4", 1);
    access(6'h00, 1'b0, 16'h0, "R4", 1);

    // R12: unmapped addresses
    access(6'h08, 1'b1, 16'hFFFF, "R12", 1);
    access(6'h18, 1'b1, 16'h1234, "R12", 1);
    access(6'h26, 1'b1, 16'h4321, "R12", 1);
    access(6'h3F, 1'b1, 16'hBEEF, "R12", 1);
    access(6'h08, 1'b0, 16'h0, "R12", 1);
    read_all("R12");

    // R10: write then read same register; rd_data shows old value first
    access(6'h00, 1'b1, 16'h0, "R10", 1);
    access(6'h13, 1'b1, 16'h7E7E, "R10", 1);
    access(6'h13, 1'b0, 16'h0, "R10", 1);

    // R5 R6: lock pin field with protect on in one write
    access(6'h00, 1'b1, 16'h0003, "R5", 1);
    access(6'h00, 1'b1, 16'h0000, "R5", 1);
    access(6'h00, 1'b1, 16'h0004, "R6", 1);
    access(6'h00, 1'b0, 16'h0, "R6", 1);
    access(6'h00, 1'b1, 16'h0000, "R6", 1);
    hit_groups(16'h9C31, "R6");
    // lock clock field with protect off
    access(6'h00, 1'b1, 16'h0008, "R5", 1);
    access(6'h00, 1'b1, 16'h0004, "R5", 1);
    access(6'h00, 1'b0, 16'h0, "R5", 1);
    hit_groups(16'h2468, "R5");
    read_all("R5");

    // R3: reset unlocks; storage kept
    do_reset();
    read_all("R3");
    // R5: lock pin field with protect off, then clock with protect on
    access(6'h00, 1'b1, 16'h0002, "R5", 1);
    access(6'h00, 1'b1, 16'h0001, "R5", 1);
    access(6'h00, 1'b1, 16'h000D, "R6", 1);
    access(6'h00, 1'b1, 16'h0000, "R6", 1);
    hit_groups(16'hF00D, "R9");
    read_all("R9");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule